// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block turns a requested state for one half-bridge leg (upper switch on, lower switch on, or both off) into timed enables for the two gate drivers of that leg. Each gate has four enables: a strong and a weak current source that pull it up, and a strong and a weak current sink that pull it down. Exactly one of them is active per gate at any time. A change of state follows a fixed order. First the conducting gate gets a strong sink burst. Then a programmable digital dead time runs with both gates held weakly low. Then the new gate gets a strong source burst, and after that only a weak source holds it on.

Requests arrive on a valid/ready stream with room for one pending request. A request that arrives while a sequence is running waits in that slot and is applied once the leg reaches a steady state. While the slot is full, `req_ready` is low and the sender must hold its request. The block also turns a two-bit source-strength code into source and sink current levels for the analog drivers.

Top module: `hbgd_sequencer`

## Requirements
- R1: After reset both gates show only the weak sink enable, and `req_ready` is high.
- R2: The upper and lower gates never have a source enable (strong or weak) active in the same cycle.
- R3: In every cycle exactly one of the four enables of each gate is active.
- R4: When a conducting gate turns off, its strong sink is active for STRONG_CYC (default 16) cycles, after which only its weak sink is active.
- R5: When a gate turns on, its strong source is active for STRONG_CYC cycles, after which only its weak source holds it until the next change.
- R6: Between the end of a strong sink burst and the following strong source burst, both gates show weak sink for 8*(dead_code+1) cycles. `dead_code` is read in the cycle the sink burst ends.
- R7: Starting from both-off, the strong source burst begins directly, with no dead time.
- R8: While the upper gate is in its strong source burst, the lower gate has its strong sink active. While the lower gate is in its strong source burst, the upper gate shows weak sink.
- R9: `req_leg` encoding: 0 = both off, 1 = upper on, 2 = lower on, 3 = both off. A request equal to the current state leaves every output unchanged.
- R10: A handshake (`req_valid` and `req_ready` high at a clock edge) fills a one-entry slot. `req_ready` stays low while the slot is full. The slot is emptied only after one cycle of steady hold state, and the next sequence starts in the cycle after that.
- R11: `src_units` equals `src_code`+1 (units of 50 mA) and `snk_units` equals 2*(`src_code`+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request slot empty |
| req_leg | input | 2 | Requested leg state (R9 encoding) |
| dead_code | input | 2 | Dead-time selection |
| src_code | input | 2 | Source drive-strength selection |
| hs_src_strong | output | 1 | Upper gate strong source |
| hs_src_weak | output | 1 | Upper gate weak source |
| hs_snk_strong | output | 1 | Upper gate strong sink |
| hs_snk_weak | output | 1 | Upper gate weak sink |
| ls_src_strong | output | 1 | Lower gate strong source |
| ls_src_weak | output | 1 | Lower gate weak source |
| ls_snk_strong | output | 1 | Lower gate strong sink |
| ls_snk_weak | output | 1 | Lower gate weak sink |
| src_units | output | 3 | Source current level |
| snk_units | output | 4 | Sink current level |

## Verification
The hardest cases to reach from the ports depend on when an input changes relative to an internal phase. One is a request that lands during a running sequence. The other is a dead-time code that changes after acceptance but before the sink burst ends. The stimulus counts cycles from the handshake: it sends a second request five cycles into a strong source burst, and it raises the dead-time code one cycle after a request is accepted. The scoreboard predicts each output segment and its length, including the single cycle of steady hold before the slot empties.

// File: rtl/hbgd_pkg.sv
package hbgd_pkg;

  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2,
    LEG_RSVD = 2'd3
  } leg_e;

  typedef enum logic [1:0] {
    PH_HOLD,
    PH_RELEASE,
    PH_GAP,
    PH_ENGAGE
  } phase_e;

  typedef struct packed {
    logic src_strong;
    logic src_weak;
    logic snk_strong;
    logic snk_weak;
  } gate_en_t;

  localparam gate_en_t EN_SRC_STRONG = 4'b1000;
  localparam gate_en_t EN_SRC_WEAK   = 4'b0100;
  localparam gate_en_t EN_SNK_STRONG = 4'b0010;
  localparam gate_en_t EN_SNK_WEAK   = 4'b0001;

endpackage

// File: rtl/hbgd_req_slot.sv
module hbgd_req_slot
  import hbgd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] in_code,
  input  logic       pop,
  output logic       out_valid,
  output leg_e       out_leg
);

  logic held;
  leg_e held_leg;
  leg_e code_leg;

  // reserved code folds onto both-off
  always_comb begin
    code_leg = leg_e'(in_code);
    if (code_leg == LEG_RSVD) code_leg = LEG_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held     <= 1'b0;
      held_leg <= LEG_OFF;
    end else if (in_valid && in_ready) begin
      held     <= 1'b1;
      held_leg <= code_leg;
    end else if (pop) begin
      held     <= 1'b0;
    end
  end

  assign in_ready  = !held;
  assign out_valid = held;
  assign out_leg   = held_leg;

endmodule

// File: rtl/hbgd_phase_timer.sv
module hbgd_phase_timer #(
  parameter int STRONG_CYC = 16,
  parameter int DT_UNIT    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_strong,
  input  logic       load_gap,
  input  logic [1:0] dt_code,
  output logic       expired
);

  localparam int GAP_MAX = DT_UNIT * 4;
  localparam int SPAN    = (STRONG_CYC > GAP_MAX) ? STRONG_CYC : GAP_MAX;
  localparam int CW      = $clog2(SPAN);

  logic [CW-1:0] cnt;
  logic [CW-1:0] gap_last;
  logic [CW-1:0] strong_last;

  always_comb begin
    gap_last    = CW'(DT_UNIT * (int'(dt_code) + 1) - 1);
    strong_last = CW'(STRONG_CYC - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (load_strong)     cnt <= strong_last;
    else if (load_gap)        cnt <= gap_last;
    else if (cnt != '0)       cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/hbgd_gate_map.sv
module hbgd_gate_map
  import hbgd_pkg::*;
#(
  parameter bit IS_HIGH = 1'b1
) (
  input  phase_e   phase,
  input  leg_e     cur_leg,
  input  leg_e     tgt_leg,
  output gate_en_t en
);

  localparam leg_e MY_LEG = IS_HIGH ? LEG_HIGH : LEG_LOW;

  always_comb begin
    en = EN_SNK_WEAK;
    unique case (phase)
      PH_HOLD:    en = (cur_leg == MY_LEG) ? EN_SRC_WEAK : EN_SNK_WEAK;
      PH_RELEASE: en = (cur_leg == MY_LEG) ? EN_SNK_STRONG : EN_SNK_WEAK;
      PH_GAP:     en = EN_SNK_WEAK;
      PH_ENGAGE: begin
        if (tgt_leg == MY_LEG)                 en = EN_SRC_STRONG;
        else if (!IS_HIGH && tgt_leg == LEG_HIGH) en = EN_SNK_STRONG;
        else                                   en = EN_SNK_WEAK;
      end
      default:    en = EN_SNK_WEAK;
    endcase
  end

endmodule

// File: rtl/hbgd_drive_level.sv
module hbgd_drive_level #(
  parameter int LVL_W = 3
) (
  input  logic [1:0]     code,
  output logic [LVL_W-1:0] src_units,
  output logic [LVL_W:0]   snk_units
);

  always_comb begin
    src_units = LVL_W'(code) + 1'b1;
    snk_units = {src_units, 1'b0};
  end

endmodule

// File: rtl/hbgd_sequencer.sv
module hbgd_sequencer
  import hbgd_pkg::*;
#(
  parameter int STRONG_CYC = 16,
  parameter int DT_UNIT    = 8,
  parameter int LVL_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_leg,
  input  logic [1:0]       dead_code,
  input  logic [1:0]       src_code,
  output logic             hs_src_strong,
  output logic             hs_src_weak,
  output logic             hs_snk_strong,
  output logic             hs_snk_weak,
  output logic             ls_src_strong,
  output logic             ls_src_weak,
  output logic             ls_snk_strong,
  output logic             ls_snk_weak,
  output logic [LVL_W-1:0] src_units,
  output logic [LVL_W:0]   snk_units
);

  localparam int NGATE = 2;

  phase_e phase, phase_n;
  leg_e   cur_leg, cur_n, tgt_leg, tgt_n;
  logic   slot_vld, slot_pop;
  leg_e   slot_leg;
  logic   ld_strong, ld_gap, expired;
  gate_en_t gate_en [NGATE];

  hbgd_req_slot u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_code  (req_leg),
    .pop      (slot_pop),
    .out_valid(slot_vld),
    .out_leg  (slot_leg)
  );

  hbgd_phase_timer #(.STRONG_CYC(STRONG_CYC), .DT_UNIT(DT_UNIT)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_strong(ld_strong),
    .load_gap   (ld_gap),
    .dt_code    (dead_code),
    .expired    (expired)
  );

  always_comb begin
    phase_n   = phase;
    cur_n     = cur_leg;
    tgt_n     = tgt_leg;
    slot_pop  = 1'b0;
    ld_strong = 1'b0;
    ld_gap    = 1'b0;
    unique case (phase)
      PH_HOLD: begin
        if (slot_vld) begin
          slot_pop = 1'b1;
          if (slot_leg != cur_leg) begin
            tgt_n     = slot_leg;
            ld_strong = 1'b1;
            phase_n   = (cur_leg == LEG_OFF) ? PH_ENGAGE : PH_RELEASE;
          end
        end
      end
      PH_RELEASE: begin
        if (expired) begin
          if (tgt_leg == LEG_OFF) begin
            cur_n   = LEG_OFF;
            phase_n = PH_HOLD;
          end else begin
            ld_gap  = 1'b1;
            phase_n = PH_GAP;
          end
        end
      end
      PH_GAP: begin
        if (expired) begin
          ld_strong = 1'b1;
          phase_n   = PH_ENGAGE;
        end
      end
      PH_ENGAGE: begin
        if (expired) begin
          cur_n   = tgt_leg;
          phase_n = PH_HOLD;
        end
      end
      default: phase_n = PH_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_HOLD;
      cur_leg <= LEG_OFF;
      tgt_leg <= LEG_OFF;
    end else begin
      phase   <= phase_n;
      cur_leg <= cur_n;
      tgt_leg <= tgt_n;
    end
  end

  for (genvar g = 0; g < NGATE; g++) begin : g_gate
    hbgd_gate_map #(.IS_HIGH(g == 0)) u_map (
      .phase  (phase),
      .cur_leg(cur_leg),
      .tgt_leg(tgt_leg),
      .en     (gate_en[g])
    );
  end

  assign {hs_src_strong, hs_src_weak, hs_snk_strong, hs_snk_weak} = gate_en[0];
  assign {ls_src_strong, ls_src_weak, ls_snk_strong, ls_snk_weak} = gate_en[1];

  hbgd_drive_level #(.LVL_W(LVL_W)) u_level (
    .code     (src_code),
    .src_units(src_units),
    .snk_units(snk_units)
  );

endmodule

// File: rtl/hbgd_sequencer_chk.sv
module hbgd_sequencer_chk #(
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_leg,
  input logic [1:0]       dead_code,
  input logic [1:0]       src_code,
  input logic             hs_src_strong,
  input logic             hs_src_weak,
  input logic             hs_snk_strong,
  input logic             hs_snk_weak,
  input logic             ls_src_strong,
  input logic             ls_src_weak,
  input logic             ls_snk_strong,
  input logic             ls_snk_weak,
  input logic [LVL_W-1:0] src_units,
  input logic [LVL_W:0]   snk_units
);

  // R2
  no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((hs_src_strong || hs_src_weak) && (ls_src_strong || ls_src_weak)));

  // R3
  hs_one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hs_src_strong, hs_src_weak, hs_snk_strong, hs_snk_weak}) == 1);

  // R3
  ls_one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ls_src_strong, ls_src_weak, ls_snk_strong, ls_snk_weak}) == 1);

  // R5
  hs_weak_after_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_src_weak) |-> $past(hs_src_strong));

  // R5
  ls_weak_after_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_src_weak) |-> $past(ls_src_strong));

  // R4
  hs_release_strong_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_src_weak) |-> hs_snk_strong);

  // R4
  ls_release_strong_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ls_src_weak) |-> ls_snk_strong);

  // R8
  low_pulled_during_high_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_src_strong |-> ls_snk_strong);

  // R10
  slot_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R11
  sink_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snk_units == {src_units, 1'b0});

endmodule

bind hbgd_sequencer hbgd_sequencer_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/hbgd_sequencer_bench.sv
module hbgd_sequencer_bench;

  localparam int S = 16;
  localparam logic [3:0] SS = 4'b1000, WS = 4'b0100, KS = 4'b0010, KW = 4'b0001;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready;
  logic [1:0] req_leg, dead_code, src_code;
  logic       hs_src_strong, hs_src_weak, hs_snk_strong, hs_snk_weak;
  logic       ls_src_strong, ls_src_weak, ls_snk_strong, ls_snk_weak;
  logic [2:0] src_units;
  logic [3:0] snk_units;

  int n_chk = 0, n_bad = 0;
  logic [7:0] q_word[$];
  int         q_len[$];
  string      q_tag[$];
  int         model_leg = 0;

  logic [7:0] seg_word;
  int         seg_len, run;
  string      seg_tag;
  bit         mon_on = 0;

  always #10 clk = ~clk;

  hbgd_sequencer u_hbgd_sequencer (.*);

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] w_stable(int leg);
    if (leg == 1) return {WS, KW};
    if (leg == 2) return {KW, WS};
    return {KW, KW};
  endfunction

  task automatic push(logic [7:0] w, int len, string tag);
    q_word.push_back(w); q_len.push_back(len); q_tag.push_back(tag);
  endtask

  // expected segments per R4..R8
  task automatic push_seq(int leg, int dt);
    int t;
    t = (leg == 3) ? 0 : leg;
    if (t == model_leg) return;
    if (model_leg != 0) begin
      push((model_leg == 1) ? {KS, KW} : {KW, KS}, S, "R4");
      if (t == 0) push(w_stable(0), 0, "R4");
      else push({KW, KW}, 8 * (dt + 1), "R6");
    end
    if (t != 0) begin
      push((t == 1) ? {SS, KS} : {KW, SS}, S, (model_leg == 0) ? "R7" : "R8");
      push(w_stable(t), 0, "R5");
    end
    model_leg = t;
  endtask

  task automatic send_req(logic [1:0] v);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_leg   = v;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_settle(int extra);
    while (q_word.size() != 0) @(negedge clk);
    repeat (extra) @(negedge clk);
  endtask

  // monitor: compare output segments and their lengths
  always @(negedge clk) begin
    logic [7:0] w;
    if (rst_n) begin
      w = {hs_src_strong, hs_src_weak, hs_snk_strong, hs_snk_weak,
           ls_src_strong, ls_src_weak, ls_snk_strong, ls_snk_weak};
      if (!mon_on) begin
        mon_on = 1;
        chk(w == {KW, KW}, "R1", int'(w), int'({KW, KW}));
        seg_word = w; seg_len = 0; seg_tag = "R1"; run = 1;
      end else if (w == seg_word) begin
        run++;
      end else begin
        if (seg_len != 0) chk(run == seg_len, seg_tag, run, seg_len);
        if (q_word.size() == 0) begin
          chk(1'b0, "R9", int'(w), int'(seg_word));
          seg_len = 0;
        end else begin
          seg_tag = q_tag.pop_front();
          seg_len = q_len.pop_front();
          chk(w == q_word[0], seg_tag, int'(w), int'(q_word[0]));
          void'(q_word.pop_front());
        end
        seg_word = w; run = 1;
      end
      chk(!((w[7] | w[6]) & (w[3] | w[2])), "R2", int'(w), 0);
      chk($countones(w[7:4]) == 1 && $countones(w[3:0]) == 1, "R3", int'(w), 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_leg = 2'd0; dead_code = 2'd0; src_code = 2'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", int'(req_ready), 1);

    for (int c = 0; c < 4; c++) begin
      src_code = 2'(c);
      #1;
      chk(src_units == 3'(c + 1), "R11", int'(src_units), c + 1);
      chk(snk_units == 4'(2 * (c + 1)), "R11", int'(snk_units), 2 * (c + 1));
    end

    push_seq(1, 0); send_req(2'd1); wait_settle(4);
    push_seq(2, 0); send_req(2'd2); wait_settle(4);
    // R6: code raised after acceptance, before the sink burst ends
    push_seq(1, 3); send_req(2'd1); dead_code = 2'd3; wait_settle(4);
    // R9: same state requested, nothing may move
    send_req(2'd1);
    repeat (60) @(negedge clk);
    chk(req_ready == 1'b1, "R9", int'(req_ready), 1);
    push_seq(0, 3); send_req(2'd0); wait_settle(4);
    // R10: second request lands inside a strong burst
    dead_code = 2'd1;
    push_seq(2, 1); send_req(2'd2);
    repeat (5) @(negedge clk);
    q_len[q_len.size() - 1] = 1;
    push_seq(1, 1); send_req(2'd1);
    chk(req_ready == 1'b0, "R10", int'(req_ready), 0);
    wait_settle(4);
    dead_code = 2'd2;
    push_seq(2, 2); send_req(2'd2); wait_settle(4);
    push_seq(3, 2); send_req(2'd3); wait_settle(20);
    chk(q_word.size() == 0, "R4", q_word.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule